// File: doc/BRIEF.md
# Timer Read-Back Latch Sequencer

This block serves the latch-and-read path of a single 16-bit down-counter in a legacy-style programmable interval timer. Software issues a read-back command that can freeze the counter's current count, its status byte, or both. Byte-wide reads then drain the frozen data in a fixed order: the status byte always comes first, then the one or two count bytes the counter's access mode calls for. After that, reads fall back to the live count. Counting, gate handling and output generation are outside the block; the live count and the live status arrive as plain inputs.

Each kind of frozen data has a valid flag, and a latch command of a kind is honoured only while that kind's flag is clear. The pair of flags is kept as a four-state machine: `RB_IDLE` (nothing held), `RB_CNT` (count held), `RB_STS` (status held) and `RB_BOTH` (both held). The transitions are as follows. From `RB_IDLE`, a command moves the machine to the state named by its select bits. `RB_STS` goes to `RB_IDLE` on a read and to `RB_BOTH` on a count command. `RB_CNT` goes to `RB_BOTH` on a status command, and goes to `RB_IDLE` on the read that takes its final count byte. `RB_BOTH` goes to `RB_CNT` on a read, because that read takes the status byte. A byte toggle chooses low or high for count reads in the two-byte access mode. It is shared by frozen and live reads and is cleared by reset or by a reprogram strobe.

The read data output is combinational. While `rd_stb` is high, `rd_data` shows the byte that the read returns, and the clock edge that ends the cycle consumes that byte.

Top module: `tmr_readback_seq`

## Requirements
- R1: A synchronous active-high `rst` clears both valid flags and the byte toggle, so the next read in two-byte mode returns the low byte of `live_cnt` even if data was held before the reset.
- R2: A count command (`cmd_stb` with `cmd_cnt`=1) accepted at a clock edge captures `live_cnt` at that edge. Later count reads return the captured value whatever `live_cnt` does afterwards.
- R3: While the count (or status) flag is set, further count (or status) latch commands are ignored, and the held value reads back unchanged.
- R4: A status command (`cmd_sts`=1) captures `live_sts`. With only the status held, one read returns it and the next read returns live count.
- R5: When both are held, the first read returns the held status. This applies to a single command with both select bits and to two separate commands in either order.
- R6: The held count is read as follows. `acc_mode` 2'b11 or 2'b00 gives the low byte and then the high byte (two reads). 2'b01 gives the low byte only (one read). 2'b10 gives the high byte only (one read).
- R7: Once the held data has been read out, reads return bytes of `live_cnt`, selected by the same mode rules.
- R8: In two-byte mode, every count read (held or live) flips the byte toggle. A status read leaves the toggle unchanged.
- R9: `prog_stb` clears the byte toggle, so the next two-byte count read returns the low byte.
- R10: When a read and a latch command share a cycle, the read returns and consumes data according to the flags before that edge. The command's acceptance is also judged on the flags before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | Read-back command strobe |
| cmd_cnt | input | 1 | Command selects a count latch |
| cmd_sts | input | 1 | Command selects a status latch |
| rd_stb | input | 1 | Byte read strobe; the byte is consumed at the clock edge |
| prog_stb | input | 1 | Counter reprogram strobe; clears the byte toggle |
| acc_mode | input | 2 | 01 low only, 10 high only, 11/00 low then high |
| live_cnt | input | 16 | Live count of the counter |
| live_sts | input | 8 | Live status byte |
| rd_data | output | 8 | Byte returned by a read in this cycle |

## Verification
The bench sweeps each access mode against five latch patterns: count only, status only, both in one command, status then count, and count then status. After each latch it changes the live inputs and repeats the latch, so that a byte returned from the held copy can be told apart from one taken from the live inputs. Other runs check that a status read does not move the toggle, that a reprogram clears the toggle, and that a reset drops held data. Three same-cycle read-and-command cases separate old-state resolution from new-state resolution: status held, count held in a one-byte mode, and nothing held.

// File: rtl/tmr_rb_pkg.sv
package tmr_rb_pkg;

    // bit 1: status held, bit 0: count held
    typedef enum logic [1:0] {
        RB_IDLE = 2'b00,
        RB_CNT  = 2'b01,
        RB_STS  = 2'b10,
        RB_BOTH = 2'b11
    } rb_state_t;

    typedef enum logic [1:0] {
        AM_PAIR_ALT = 2'b00,
        AM_LOW      = 2'b01,
        AM_HIGH     = 2'b10,
        AM_PAIR     = 2'b11
    } acc_mode_t;

    function automatic logic mode_is_pair(input logic [1:0] m);
        return (m == AM_PAIR) || (m == AM_PAIR_ALT);
    endfunction

endpackage

// File: rtl/rb_latch_fsm.sv
module rb_latch_fsm
    import tmr_rb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_stb,
    input  logic cmd_cnt,
    input  logic cmd_sts,
    input  logic rd_stb,
    input  logic pair_mode,
    input  logic tog,
    output logic cnt_v,
    output logic sts_v,
    output logic cap_cnt,
    output logic cap_sts
);

    rb_state_t state, nxt;

    logic want_cnt, want_sts, last_cnt_byte;

    assign want_cnt      = cmd_stb & cmd_cnt;
    assign want_sts      = cmd_stb & cmd_sts;
    assign last_cnt_byte = ~pair_mode | tog;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RB_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions: reads act on the current state, commands are judged on it too
    always_comb begin
        nxt = state;
        unique case (state)
            RB_IDLE: nxt = rb_state_t'({want_sts, want_cnt});
            RB_STS:  nxt = rb_state_t'({~rd_stb, want_cnt});
            RB_CNT:  nxt = rb_state_t'({want_sts, ~(rd_stb & last_cnt_byte)});
            RB_BOTH: nxt = rb_state_t'({~rd_stb, 1'b1});
            default: nxt = RB_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cnt_v   = 1'b0;
        sts_v   = 1'b0;
        unique case (state)
            RB_IDLE: begin cnt_v = 1'b0; sts_v = 1'b0; end
            RB_CNT:  begin cnt_v = 1'b1; sts_v = 1'b0; end
            RB_STS:  begin cnt_v = 1'b0; sts_v = 1'b1; end
            RB_BOTH: begin cnt_v = 1'b1; sts_v = 1'b1; end
            default: begin cnt_v = 1'b0; sts_v = 1'b0; end
        endcase
        cap_cnt = want_cnt & ~cnt_v;
        cap_sts = want_sts & ~sts_v;
    end

endmodule

// File: rtl/rb_hold_regs.sv
module rb_hold_regs #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cap_cnt,
    input  logic                cap_sts,
    input  logic [2*BYTE_W-1:0] live_cnt,
    input  logic [BYTE_W-1:0]   live_sts,
    output logic [2*BYTE_W-1:0] cnt_hold,
    output logic [BYTE_W-1:0]   sts_hold
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_hold <= '0;
            sts_hold <= '0;
        end else begin
            if (cap_cnt) cnt_hold <= live_cnt;
            if (cap_sts) sts_hold <= live_sts;
        end
    end

endmodule

// File: rtl/rb_byte_sel.sv
module rb_byte_sel
    import tmr_rb_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                prog_stb,
    input  logic                rd_stb,
    input  logic [1:0]          acc_mode,
    input  logic                pair_mode,
    input  logic                sts_v,
    input  logic                cnt_v,
    input  logic [2*BYTE_W-1:0] cnt_hold,
    input  logic [BYTE_W-1:0]   sts_hold,
    input  logic [2*BYTE_W-1:0] live_cnt,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                tog
);

    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0] src;
    logic             pick_hi;

    always_ff @(posedge clk) begin
        if (rst || prog_stb) begin
            tog <= 1'b0;
        end else if (rd_stb && !sts_v && pair_mode) begin
            tog <= ~tog;
        end
    end

    always_comb begin
        src     = cnt_v ? cnt_hold : live_cnt;
        pick_hi = (acc_mode == AM_HIGH) | (pair_mode & tog);
        if (sts_v) begin
            rd_data = sts_hold;
        end else if (pick_hi) begin
            rd_data = src[CNT_W-1:BYTE_W];
        end else begin
            rd_data = src[BYTE_W-1:0];
        end
    end

endmodule

// File: rtl/tmr_readback_seq.sv
module tmr_readback_seq
    import tmr_rb_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_stb,
    input  logic                cmd_cnt,
    input  logic                cmd_sts,
    input  logic                rd_stb,
    input  logic                prog_stb,
    input  logic [1:0]          acc_mode,
    input  logic [2*BYTE_W-1:0] live_cnt,
    input  logic [BYTE_W-1:0]   live_sts,
    output logic [BYTE_W-1:0]   rd_data
);

    localparam int CNT_W = 2 * BYTE_W;

    logic             pair_mode;
    logic             cnt_v, sts_v, cap_cnt, cap_sts, tog;
    logic [CNT_W-1:0] cnt_hold;
    logic [BYTE_W-1:0] sts_hold;

    assign pair_mode = mode_is_pair(acc_mode);

    rb_latch_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd_stb   (cmd_stb),
        .cmd_cnt   (cmd_cnt),
        .cmd_sts   (cmd_sts),
        .rd_stb    (rd_stb),
        .pair_mode (pair_mode),
        .tog       (tog),
        .cnt_v     (cnt_v),
        .sts_v     (sts_v),
        .cap_cnt   (cap_cnt),
        .cap_sts   (cap_sts)
    );

    rb_hold_regs #(.BYTE_W(BYTE_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .cap_cnt  (cap_cnt),
        .cap_sts  (cap_sts),
        .live_cnt (live_cnt),
        .live_sts (live_sts),
        .cnt_hold (cnt_hold),
        .sts_hold (sts_hold)
    );

    rb_byte_sel #(.BYTE_W(BYTE_W)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .prog_stb  (prog_stb),
        .rd_stb    (rd_stb),
        .acc_mode  (acc_mode),
        .pair_mode (pair_mode),
        .sts_v     (sts_v),
        .cnt_v     (cnt_v),
        .cnt_hold  (cnt_hold),
        .sts_hold  (sts_hold),
        .live_cnt  (live_cnt),
        .rd_data   (rd_data),
        .tog       (tog)
    );

endmodule

// File: rtl/tmr_readback_seq_chk.sv
module tmr_readback_seq_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_stb,
    input logic                cmd_cnt,
    input logic                cmd_sts,
    input logic                rd_stb,
    input logic                prog_stb,
    input logic [1:0]          acc_mode,
    input logic [2*BYTE_W-1:0] live_cnt,
    input logic [BYTE_W-1:0]   rd_data,
    input logic                sts_v,
    input logic                cnt_v,
    input logic                tog
);

    localparam int CNT_W = 2 * BYTE_W;

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!sts_v && !cnt_v && !tog));

    assert_sts_repeat_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && cmd_sts && sts_v && !rd_stb) |=> (sts_v && rd_data == $past(rd_data)));

    assert_cnt_repeat_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && cmd_cnt && cnt_v && !rd_stb) |=> cnt_v);

    assert_status_read_first_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && sts_v) |=> (!sts_v && (cnt_v || !$past(cnt_v))));

    assert_single_byte_drain_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !sts_v && cnt_v && (acc_mode == 2'b01 || acc_mode == 2'b10)
         && !(cmd_stb && cmd_cnt)) |=> !cnt_v);

    assert_live_low_R7: assert property (@(posedge clk) disable iff (rst)
        (!sts_v && !cnt_v && acc_mode == 2'b01) |-> (rd_data == live_cnt[BYTE_W-1:0]));

    assert_live_high_R7: assert property (@(posedge clk) disable iff (rst)
        (!sts_v && !cnt_v && acc_mode == 2'b10) |-> (rd_data == live_cnt[CNT_W-1:BYTE_W]));

    assert_status_keeps_toggle_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && sts_v && !prog_stb) |=> (tog == $past(tog)));

    assert_prog_clears_toggle_R9: assert property (@(posedge clk) disable iff (rst)
        prog_stb |=> !tog);

endmodule

bind tmr_readback_seq tmr_readback_seq_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_stb  (cmd_stb),
    .cmd_cnt  (cmd_cnt),
    .cmd_sts  (cmd_sts),
    .rd_stb   (rd_stb),
    .prog_stb (prog_stb),
    .acc_mode (acc_mode),
    .live_cnt (live_cnt),
    .rd_data  (rd_data),
    .sts_v    (sts_v),
    .cnt_v    (cnt_v),
    .tog      (tog)
);

// File: tb/test_tmr_readback_seq.sv
module test_tmr_readback_seq;

    logic        clk = 1'b0;
    logic        rst, cmd_stb, cmd_cnt, cmd_sts, rd_stb, prog_stb;
    logic [1:0]  acc_mode;
    logic [15:0] live_cnt;
    logic [7:0]  live_sts;
    logic [7:0]  rd_data;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    tmr_readback_seq i_tmr_readback_seq (
        .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_cnt(cmd_cnt), .cmd_sts(cmd_sts),
        .rd_stb(rd_stb), .prog_stb(prog_stb), .acc_mode(acc_mode),
        .live_cnt(live_cnt), .live_sts(live_sts), .rd_data(rd_data)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic cmd(input logic c, input logic s);
        cmd_stb = 1'b1; cmd_cnt = c; cmd_sts = s;
        tick();
        cmd_stb = 1'b0; cmd_cnt = 1'b0; cmd_sts = 1'b0;
    endtask

    task automatic rd(input logic [7:0] exp, input string req);
        rd_stb = 1'b1;
        #1 chk({8'h00, rd_data}, {8'h00, exp}, req);
        tick();
        rd_stb = 1'b0;
    endtask

    task automatic prog();
        prog_stb = 1'b1; tick(); prog_stb = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; tick(); tick(); rst = 1'b0;
    endtask

    // kind: 0 count, 1 status, 2 both in one command, 3 status then count, 4 count then status
    task automatic run_case(input logic [1:0] mode, input int kind);
        logic [15:0] l1, l2;
        logic [7:0]  s1, s2;
        logic        has_c, has_s, pair;
        l1 = 16'h1357 + 16'h1111 * 16'(mode) + 16'h0203 * 16'(kind);
        s1 = 8'h81 + 8'h10 * 8'(kind) + 8'(mode);
        l2 = ~l1;
        s2 = ~s1;
        has_c = (kind != 1);
        has_s = (kind != 0);
        pair  = (mode == 2'b11) || (mode == 2'b00);
        acc_mode = mode;
        prog();
        live_cnt = l1; live_sts = s1;
        case (kind)
            0: cmd(1'b1, 1'b0);
            1: cmd(1'b0, 1'b1);
            2: cmd(1'b1, 1'b1);
            3: begin cmd(1'b0, 1'b1); cmd(1'b1, 1'b0); end
            default: begin cmd(1'b1, 1'b0); cmd(1'b0, 1'b1); end
        endcase
        live_cnt = l2; live_sts = s2;
        cmd(has_c, has_s); // repeat must be ignored (R3)
        if (has_s) rd(s1, "R5/R4 status first, repeat ignored R3");
        if (has_c) begin
            if (pair) begin
                rd(l1[7:0],  "R6 held low byte R2");
                rd(l1[15:8], "R6 held high byte R2");
            end else if (mode == 2'b01) begin
                rd(l1[7:0],  "R6 held low only R2");
            end else begin
                rd(l1[15:8], "R6 held high only R2");
            end
        end
        if (pair) begin
            rd(l2[7:0],  "R7 live low after drain");
            rd(l2[15:8], "R7/R8 live high after drain");
        end else if (mode == 2'b01) begin
            rd(l2[7:0],  "R7 live low only");
        end else begin
            rd(l2[15:8], "R7 live high only");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_stb = 1'b0; cmd_cnt = 1'b0; cmd_sts = 1'b0;
        rd_stb = 1'b0; prog_stb = 1'b0; acc_mode = 2'b11;
        live_cnt = 16'hBEEF; live_sts = 8'h5A;
        @(negedge clk);
        do_reset();

        // R1: reset state reads live, low first
        rd(8'hEF, "R1 reset live low");
        rd(8'hBE, "R1 live high");

        // R1: reset drops held status and count
        cmd(1'b1, 1'b1);
        live_cnt = 16'hC0DE;
        do_reset();
        rd(8'hDE, "R1 reset drops held data");

        // sweep all modes and latch patterns
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 5; k++) begin
                run_case(2'(m), k);
            end
        end

        // R8: status read does not move toggle
        acc_mode = 2'b11; prog();
        live_cnt = 16'hA1B2; live_sts = 8'h3C;
        rd(8'hB2, "R8 live low");
        cmd(1'b0, 1'b1);
        rd(8'h3C, "R8 status read");
        rd(8'hA1, "R8 toggle kept across status read");

        // R9: reprogram clears toggle
        rd(8'hB2, "R9 live low");
        prog();
        rd(8'hB2, "R9 low after reprogram");
        rd(8'hA1, "R9 high next");

        // R10 a: status held, read and status command together
        live_sts = 8'h11;
        cmd(1'b0, 1'b1);
        live_sts = 8'h22; live_cnt = 16'h7788;
        cmd_stb = 1'b1; cmd_sts = 1'b1; rd_stb = 1'b1;
        #1 chk({8'h00, rd_data}, 16'h0011, "R10 read sees old status");
        tick();
        cmd_stb = 1'b0; cmd_sts = 1'b0; rd_stb = 1'b0;
        rd(8'h88, "R10 status command ignored, live follows");
        rd(8'h77, "R10 live high");

        // R10 b: count held in low-only mode, read and count command together
        acc_mode = 2'b01;
        live_cnt = 16'h0F1E;
        cmd(1'b1, 1'b0);
        live_cnt = 16'h2D3C;
        cmd_stb = 1'b1; cmd_cnt = 1'b1; rd_stb = 1'b1;
        #1 chk({8'h00, rd_data}, 16'h001E, "R10 read sees old count");
        tick();
        cmd_stb = 1'b0; cmd_cnt = 1'b0; rd_stb = 1'b0;
        live_cnt = 16'h4B5A;
        rd(8'h5A, "R10 count command judged on old flag");

        // R10 c: nothing held, read and count command together
        live_cnt = 16'h6978;
        cmd_stb = 1'b1; cmd_cnt = 1'b1; rd_stb = 1'b1;
        #1 chk({8'h00, rd_data}, 16'h0078, "R10 read sees live");
        tick();
        cmd_stb = 1'b0; cmd_cnt = 1'b0; rd_stb = 1'b0;
        live_cnt = 16'h8796;
        rd(8'h78, "R10 command accepted R2");
        rd(8'h96, "R7 live after drain");

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule